// File: doc/BRIEF.md
# Addressable LED Serial Waveform Encoder

This block turns a stream of colour samples into the single-wire, return-to-zero bit train that chains of addressable RGB and RGBW LEDs expect. Each input transfer carries red, green, blue and white bytes plus an end-of-frame marker. The block accepts a transfer over a valid/ready handshake. It arranges the bytes into a 24-bit or 32-bit word in one of three byte orders and sends that word most significant bit first. All timing is counted in steps of 50 ns. A prescaler turns the core clock into this step rate: `STEP_CYC` clock cycles make one step, so a 20 MHz clock uses a value of 1.

A bit cell begins with a low phase of T1L and continues with a high phase of T0H. A one bit then stays high for a further T1H − T0H. A zero bit instead drops low for a further T0L − T1L. Each of the four timings is a parameter in nanoseconds and is cut down to whole steps. Settings that the bit cell cannot express stop elaboration with an error. These are: T0H outside 50..850 ns, T1L outside 100..1700 ns, T0L not within T1L+50..T1L+850 ns, or T1H not within T0H+100..T0H+1700 ns.

The sequencer moves through these states: IDLE (line low, ready), LOW_A (the shared low phase), HIGH_A (the shared high phase), HIGH_B (the extra high time of a one), LOW_B (the extra low time of a zero), WAIT (a word ended mid-frame and the next one is missing) and RESET (the latch interval after the last word). The transitions are:
- IDLE→LOW_A and WAIT→LOW_A on an accepted word.
- LOW_A→HIGH_A when its step count expires.
- HIGH_A→HIGH_B or HIGH_A→LOW_B, chosen by the current bit.
- HIGH_B/LOW_B→LOW_A for the next bit, or for the next word when one is offered at that moment.
- HIGH_B/LOW_B→WAIT when a mid-frame word ends and no data is offered.
- HIGH_B/LOW_B→RESET after the last word of a frame.
- RESET→IDLE after `RESET_STEPS` steps, together with a one-cycle done pulse.

Top module: `led_wave_encoder`

## Requirements
- R1: After reset, `led_dout` is 0, `in_ready` is 1, `busy` is 0 and `frame_done` is 0.
- R2: Every step lasts `STEP_CYC` clock cycles. A one bit is high for T1H/50 steps. A zero bit is high for T0H/50 steps. Within a word, the low time before a bit is T1L/50 steps if the previous bit was a one, and T0L/50 steps if it was a zero (each quotient truncated).
- R3: With `cfg_rgbw`=0 a word is 24 bits long. With `cfg_rgbw`=1 it is 32 bits long, and the white byte is the last eight bits sent. Bits go out most significant first.
- R4: `cfg_order`, sampled when a word is accepted, sets the first three bytes sent: 0 sends green, red, blue; 1 sends red, green, blue; 2 sends blue, green, red; 3 behaves like 0.
- R5: `in_ready` is raised for exactly the final cycle of a mid-frame word's last bit. A word offered in that cycle starts its first low phase with no extra cycle, so the low time at the word boundary obeys R2.
- R6: When a mid-frame word ends and no data is offered, the block waits with `led_dout` low, `in_ready` high and `busy` high until the next word arrives.
- R7: After the last bit of a frame (a word accepted with `in_last`=1), the line stays low for `RESET_STEPS` steps beyond the end of that bit cell. Then `frame_done` pulses for one cycle, and `busy` is 0 in that same cycle.
- R8: `in_ready` stays low from the acceptance of a frame's last word until `frame_done`. A word held valid during that interval is not taken and produces no line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_order | input | 2 | Byte order select, sampled per accepted word |
| cfg_rgbw | input | 1 | 1 = 32-bit words with white byte, 0 = 24-bit words |
| in_valid | input | 1 | Colour word offered |
| in_ready | output | 1 | Block takes the offered word this cycle |
| in_red | input | 8 | Red intensity |
| in_green | input | 8 | Green intensity |
| in_blue | input | 8 | Blue intensity |
| in_white | input | 8 | White intensity (used only when `cfg_rgbw`=1) |
| in_last | input | 1 | Marks the final word of a frame |
| led_dout | output | 1 | Serial LED data line, idles low |
| busy | output | 1 | A frame or its reset interval is in progress |
| frame_done | output | 1 | One-cycle pulse when the reset interval ends |

## Verification
A corrupted step counter or prescaler shows up at the very next bit cell as a high or low run that is off by whole steps. The bench checks every run length against the expected value. A shift register or bit counter that goes wrong shows up as wrong decoded colour bytes, or as a pulse count that differs from 24 or 32 per word, and this is visible once the frame ends. A sequencer stuck in the wrong state shows up within one step. In that case the line rises without a preceding low phase, `in_ready` is raised during the reset interval, or `frame_done` arrives a different number of cycles after the last falling edge.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    // Byte arrangement codes; code 3 falls back to the first arrangement.
    typedef enum logic [1:0] {
        ORD_GRB = 2'd0,
        ORD_RGB = 2'd1,
        ORD_BGR = 2'd2,
        ORD_DEF = 2'd3
    } byte_order_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOW_A  = 3'd1,
        S_HIGH_A = 3'd2,
        S_HIGH_B = 3'd3,
        S_LOW_B  = 3'd4,
        S_WAIT   = 3'd5,
        S_RESET  = 3'd6
    } enc_state_e;

    localparam int STEP_NS = 50;

endpackage

// File: rtl/led_step_tick.sv
// Divides the core clock down to the 50 ns step rate; restarts whenever
// the sequencer is parked so the first step of a burst is full length.
module led_step_tick #(
    parameter int STEP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = $clog2(STEP_CYC + 1);
    localparam logic [PW-1:0] TOP = PW'(STEP_CYC - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || pre_q == TOP) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == TOP);

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pre_q == TOP) |=> (pre_q == '0));

endmodule

// File: rtl/led_phase_cnt.sv
// Down-counter measuring one waveform phase in steps.
module led_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && (cnt_q == '0);

endmodule

// File: rtl/led_word_pack.sv
// Arranges the colour bytes into a left-aligned transmit word.
module led_word_pack
    import led_enc_pkg::*;
(
    input  logic [1:0]  order,
    input  logic        rgbw,
    input  logic [7:0]  red,
    input  logic [7:0]  green,
    input  logic [7:0]  blue,
    input  logic [7:0]  white,
    output logic [31:0] word
);
    logic [7:0] low_byte;

    always_comb begin
        low_byte = rgbw ? white : 8'h00;
        case (byte_order_e'(order))
            ORD_RGB: word = {red, green, blue, low_byte};
            ORD_BGR: word = {blue, green, red, low_byte};
            default: word = {green, red, blue, low_byte};
        endcase
    end

endmodule

// File: rtl/led_wave_encoder.sv
module led_wave_encoder #(
    parameter int STEP_CYC    = 1,
    parameter int T0H_NS      = 350,
    parameter int T0L_NS      = 800,
    parameter int T1H_NS      = 900,
    parameter int T1L_NS      = 350,
    parameter int RESET_STEPS = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_order,
    input  logic       cfg_rgbw,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_red,
    input  logic [7:0] in_green,
    input  logic [7:0] in_blue,
    input  logic [7:0] in_white,
    input  logic       in_last,
    output logic       led_dout,
    output logic       busy,
    output logic       frame_done
);
    import led_enc_pkg::*;

    // Phase lengths in steps
    localparam int ST_T1L = T1L_NS / STEP_NS;
    localparam int ST_T0H = T0H_NS / STEP_NS;
    localparam int ST_X1  = T1H_NS / STEP_NS - ST_T0H;
    localparam int ST_X0  = T0L_NS / STEP_NS - ST_T1L;
    localparam int MAX_A  = (ST_T1L > ST_T0H) ? ST_T1L : ST_T0H;
    localparam int MAX_B  = (ST_X1 > ST_X0) ? ST_X1 : ST_X0;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_MX = (MAX_C > RESET_STEPS) ? MAX_C : RESET_STEPS;
    localparam int CNT_W  = $clog2(CNT_MX + 1);

    localparam logic [CNT_W-1:0] LD_T1L = CNT_W'(ST_T1L - 1);
    localparam logic [CNT_W-1:0] LD_T0H = CNT_W'(ST_T0H - 1);
    localparam logic [CNT_W-1:0] LD_X1  = CNT_W'(ST_X1 - 1);
    localparam logic [CNT_W-1:0] LD_X0  = CNT_W'(ST_X0 - 1);
    localparam logic [CNT_W-1:0] LD_RST = CNT_W'(RESET_STEPS - 1);

    // Elaboration-time legality of the timing set
    if (T0H_NS < 50 || T0H_NS > 850) begin : g_bad_t0h
        $error("T0H_NS must lie in 50..850");
    end
    if (T1L_NS < 100 || T1L_NS > 1700) begin : g_bad_t1l
        $error("T1L_NS must lie in 100..1700");
    end
    if (T0L_NS < T1L_NS + 50 || T0L_NS > T1L_NS + 850) begin : g_bad_t0l
        $error("T0L_NS must lie in T1L_NS+50..T1L_NS+850");
    end
    if (T1H_NS < T0H_NS + 100 || T1H_NS > T0H_NS + 1700) begin : g_bad_t1h
        $error("T1H_NS must lie in T0H_NS+100..T0H_NS+1700");
    end
    if (RESET_STEPS < 1 || STEP_CYC < 1) begin : g_bad_misc
        $error("RESET_STEPS and STEP_CYC must be at least 1");
    end

    enc_state_e       state_q, state_d;
    logic [31:0]      shreg_q;
    logic [5:0]       bits_q;
    logic             last_q;
    logic             done_q;
    logic [31:0]      packed_word;
    logic             run, tick;
    logic             pt_load, pt_expire;
    logic [CNT_W-1:0] pt_val;
    logic             shift_en;
    logic             word_end;
    logic             take;

    led_word_pack u_pack (
        .order (cfg_order),
        .rgbw  (cfg_rgbw),
        .red   (in_red),
        .green (in_green),
        .blue  (in_blue),
        .white (in_white),
        .word  (packed_word)
    );

    assign run = (state_q != S_IDLE) && (state_q != S_WAIT);

    led_step_tick #(.STEP_CYC(STEP_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    led_phase_cnt #(.W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (pt_load),
        .load_val (pt_val),
        .expire   (pt_expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and phase-load decode
    always_comb begin
        state_d  = state_q;
        pt_load  = 1'b0;
        pt_val   = '0;
        shift_en = 1'b0;
        unique case (state_q)
            S_IDLE, S_WAIT: begin
                if (in_valid) begin
                    state_d = S_LOW_A;
                    pt_load = 1'b1;
                    pt_val  = LD_T1L;
                end
            end
            S_LOW_A: begin
                if (pt_expire) begin
                    state_d = S_HIGH_A;
                    pt_load = 1'b1;
                    pt_val  = LD_T0H;
                end
            end
            S_HIGH_A: begin
                if (pt_expire) begin
                    pt_load = 1'b1;
                    if (shreg_q[31]) begin
                        state_d = S_HIGH_B;
                        pt_val  = LD_X1;
                    end else begin
                        state_d = S_LOW_B;
                        pt_val  = LD_X0;
                    end
                end
            end
            S_HIGH_B, S_LOW_B: begin
                if (pt_expire) begin
                    pt_load = 1'b1;
                    if (bits_q > 6'd1) begin
                        shift_en = 1'b1;
                        state_d  = S_LOW_A;
                        pt_val   = LD_T1L;
                    end else if (last_q) begin
                        state_d = S_RESET;
                        pt_val  = LD_RST;
                    end else if (in_valid) begin
                        state_d = S_LOW_A;
                        pt_val  = LD_T1L;
                    end else begin
                        state_d = S_WAIT;
                        pt_load = 1'b0;
                    end
                end
            end
            S_RESET: begin
                if (pt_expire) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign word_end = ((state_q == S_HIGH_B) || (state_q == S_LOW_B))
                      && pt_expire && (bits_q == 6'd1);
    assign take     = in_valid && in_ready;

    // Word shifter and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bits_q  <= '0;
            last_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == S_RESET) && pt_expire;
            if (take) begin
                shreg_q <= packed_word;
                bits_q  <= cfg_rgbw ? 6'd32 : 6'd24;
                last_q  <= in_last;
            end else if (shift_en) begin
                shreg_q <= {shreg_q[30:0], 1'b0};
                bits_q  <= bits_q - 6'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        led_dout   = (state_q == S_HIGH_A) || (state_q == S_HIGH_B);
        busy       = (state_q != S_IDLE);
        in_ready   = (state_q == S_IDLE) || (state_q == S_WAIT)
                     || (word_end && !last_q);
        frame_done = done_q;
    end

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    reset_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESET) |-> !in_ready);

    // R6
    wait_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) |-> (!led_dout && in_ready && busy));

    // R2
    rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_dout) |-> ($past(state_q) == S_LOW_A));

    // R3
    bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bits_q <= 6'd32));

endmodule

// File: tb/sim_led_wave_encoder.sv
module sim_led_wave_encoder;

    localparam int STEP_CYC  = 2;
    localparam int RST_STEPS = 20;
    localparam int T0H = 350;
    localparam int T0L = 800;
    localparam int T1H = 900;
    localparam int T1L = 350;
    localparam int H0  = (T0H / 50) * STEP_CYC;
    localparam int H1  = (T1H / 50) * STEP_CYC;
    localparam int L1  = (T1L / 50) * STEP_CYC;
    localparam int L0  = (T0L / 50) * STEP_CYC;
    localparam int RSTC = RST_STEPS * STEP_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_order = 2'd0;
    logic       cfg_rgbw = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_red = 8'h0, in_green = 8'h0, in_blue = 8'h0, in_white = 8'h0;
    logic       in_last = 1'b0;
    logic       led_dout, busy, frame_done;

    always #4 clk = ~clk;

    led_wave_encoder #(
        .STEP_CYC(STEP_CYC), .T0H_NS(T0H), .T0L_NS(T0L),
        .T1H_NS(T1H), .T1L_NS(T1L), .RESET_STEPS(RST_STEPS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_rgbw(cfg_rgbw),
        .in_valid(in_valid), .in_ready(in_ready), .in_red(in_red),
        .in_green(in_green), .in_blue(in_blue), .in_white(in_white),
        .in_last(in_last), .led_dout(led_dout), .busy(busy),
        .frame_done(frame_done)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Line recorder: run lengths sampled at the falling clock edge
    bit rec = 1'b0;
    bit prev = 1'b0;
    int run_len = 0;
    int nh = 0;
    int hl [0:127];
    int ll [0:127];
    int done_gap = -1;
    bit done_busy = 1'b0;

    always @(negedge clk) begin
        if (rec) begin
            if (led_dout == prev) begin
                run_len++;
            end else begin
                if (prev) begin
                    if (nh < 128) hl[nh] = run_len;
                    nh++;
                end else if (nh < 128) begin
                    ll[nh] = run_len;
                end
                run_len = 1;
                prev = led_dout;
            end
            if (frame_done) begin
                done_gap  = run_len;
                done_busy = busy;
            end
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Frame description
    logic [7:0] fr [0:7];
    logic [7:0] fg [0:7];
    logic [7:0] fb [0:7];
    logic [7:0] fw [0:7];
    int         nw = 0;
    logic [1:0] ford = 2'd0;
    bit         fwhite = 1'b0;
    int         gap_word = -1;

    function automatic logic [31:0] exp_word(input int i);
        logic [7:0] w;
        w = fwhite ? fw[i] : 8'h00;
        case (ford)
            2'd1:    return {fr[i], fg[i], fb[i], w};
            2'd2:    return {fb[i], fg[i], fr[i], w};
            default: return {fg[i], fr[i], fb[i], w};
        endcase
    endfunction

    function automatic bit exp_bit(input int k, input int bpw);
        logic [31:0] w;
        w = exp_word(k / bpw);
        return w[31 - (k % bpw)];
    endfunction

    task automatic run_frame(input string tag);
        int  bpw;
        bit  ready_seen;
        int  guard;
        int  lim;
        logic [31:0] dec;
        bpw = fwhite ? 32 : 24;
        prev = 1'b0; run_len = 0; nh = 0; done_gap = -1; done_busy = 1'b1;
        rec = 1'b1;
        cfg_order = ford;
        cfg_rgbw  = fwhite;
        for (int i = 0; i < nw; i++) begin
            if (i == gap_word) begin
                in_valid = 1'b0;
                while (!in_ready) @(negedge clk);
                repeat (10) @(negedge clk);
                // R6: parked between words
                chk(led_dout == 1'b0, "R6 line", led_dout, 0);
                chk(in_ready == 1'b1, "R6 ready", in_ready, 1);
                chk(busy == 1'b1, "R6 busy", busy, 1);
            end
            in_red = fr[i]; in_green = fg[i]; in_blue = fb[i]; in_white = fw[i];
            in_last = (i == nw - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        // Hold a foreign word valid through the reset interval (R8)
        in_red = 8'hEE; in_green = 8'hEE; in_blue = 8'hEE; in_white = 8'hEE;
        in_last = 1'b0;
        in_valid = 1'b1;
        ready_seen = 1'b0;
        guard = 0;
        while (!frame_done && guard < 20000) begin
            if (in_ready) ready_seen = 1'b1;
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0;
        @(negedge clk);
        rec = 1'b0;
        $display("frame %s: %0d pulses", tag, nh);
        chk(!ready_seen, "R8 ready during reset", ready_seen, 0);
        chk(nh == nw * bpw, "R3 pulse count", nh, nw * bpw);
        lim = (nh < nw * bpw) ? nh : nw * bpw;
        if (lim > 128) lim = 128;
        // R4 / R3: decoded words
        for (int i = 0; i < nw; i++) begin
            dec = '0;
            for (int b = 0; b < bpw; b++) begin
                int k;
                k = i * bpw + b;
                dec = {dec[30:0], (k < lim) ? (hl[k] > (H0 + H1) / 2) : 1'b0};
            end
            if (bpw == 24) dec = {dec[23:0], 8'h00};
            chk(dec == exp_word(i), "R4 word content", dec, exp_word(i));
        end
        // R2 / R5: per-bit timing
        for (int k = 0; k < lim; k++) begin
            bit b;
            b = exp_bit(k, bpw);
            chk(hl[k] == (b ? H1 : H0), "R2 high time", hl[k], b ? H1 : H0);
            if (k > 0 && !(gap_word >= 0 && k == gap_word * bpw)) begin
                bit pb;
                pb = exp_bit(k - 1, bpw);
                if (k % bpw == 0)
                    chk(ll[k] == (pb ? L1 : L0), "R5 boundary low", ll[k], pb ? L1 : L0);
                else
                    chk(ll[k] == (pb ? L1 : L0), "R2 low time", ll[k], pb ? L1 : L0);
            end
        end
        // R7: reset interval and done pulse
        begin
            bit lb;
            int e;
            lb = exp_bit(nw * bpw - 1, bpw);
            e  = (lb ? RSTC : (L0 - L1) + RSTC) + 1;
            chk(done_gap == e, "R7 reset interval", done_gap, e);
            chk(done_busy == 1'b0, "R7 busy at done", done_busy, 0);
        end
        // R8: the held word left no trace
        repeat (8) @(negedge clk);
        chk(led_dout == 1'b0, "R8 line after frame", led_dout, 0);
        chk(busy == 1'b0, "R8 busy after frame", busy, 0);
        chk(frame_done == 1'b0, "R7 done width", frame_done, 0);
        gap_word = -1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(led_dout == 1'b0, "R1 line", led_dout, 0);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(frame_done == 1'b0, "R1 done", frame_done, 0);
    endtask

    task automatic t_grb_two();
        ford = 2'd0; fwhite = 1'b0; nw = 2;
        fr[0] = 8'hA5; fg[0] = 8'h3C; fb[0] = 8'hF0; fw[0] = 8'h77;
        fr[1] = 8'h01; fg[1] = 8'h80; fb[1] = 8'hFF; fw[1] = 8'h00;
        run_frame("grb");
    endtask

    task automatic t_rgbw_one();
        ford = 2'd1; fwhite = 1'b1; nw = 1;
        fr[0] = 8'h12; fg[0] = 8'hC3; fb[0] = 8'h00; fw[0] = 8'h5A;
        run_frame("rgbw");
    endtask

    task automatic t_bgr_three();
        ford = 2'd2; fwhite = 1'b0; nw = 3;
        fr[0] = 8'h00; fg[0] = 8'hFF; fb[0] = 8'h81;
        fr[1] = 8'hFF; fg[1] = 8'h00; fb[1] = 8'h7E;
        fr[2] = 8'h55; fg[2] = 8'hAA; fb[2] = 8'h0F;
        run_frame("bgr");
    endtask

    task automatic t_order_three();
        ford = 2'd3; fwhite = 1'b1; nw = 1;
        fr[0] = 8'h9C; fg[0] = 8'h2B; fb[0] = 8'hE4; fw[0] = 8'hC1;
        run_frame("order3");
    endtask

    task automatic t_gap();
        ford = 2'd1; fwhite = 1'b0; nw = 2; gap_word = 1;
        fr[0] = 8'hF1; fg[0] = 8'h0E; fb[0] = 8'h66;
        fr[1] = 8'h39; fg[1] = 8'hC7; fb[1] = 8'h80;
        run_frame("gap");
    endtask

    initial begin
        t_reset();
        t_grb_two();
        t_rgbw_one();
        t_bgr_three();
        t_order_three();
        t_gap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule